// File: doc/BRIEF.md
# Host Configuration Pass-Through Bridge

This block gives a host a 32-bit register port into a card whose main logic lives in an SRAM-based FPGA. Before that FPGA holds a design, the host uses the bridge to drive the FPGA's configuration pins and to push configuration words into it. A synchronized copy of the FPGA's completion flag tells the host when configuration has finished. Once the FPGA is configured, most of the bridge's byte-addressed space is passed on to the FPGA as generic read/write cycles, so the host can reach test registers inside the configured design.

The host issues one request at a time. It raises `host_rd` or `host_wr` for a single clock with the byte offset and write data, then waits for a one-cycle `host_ack` that carries the read data. The bridge also holds an identification word for the host to read. A test register returns the complement of the last value written, which lets the host check every data line of the bus. Requests that arrive while a forwarded cycle is still pending are dropped.

Top module: `hostcfg_bridge`

## Requirements
- R1: After reset the outputs `cfg_prog_n`, `cfg_write_n`, `cfg_cs_n` and `cfg_init_n` are all 1, and `app_sel` and `cfg_data_stb` are 0. The test register reads 0xFFFFFFFF. The control word at offset 0x00 reads 0x0000004E while the done input is low.
- R2: A request to any offset outside 0x08–0xEF completes with `host_ack` high in the first cycle after the request cycle, for one cycle only.
- R3: In the control word at offset 0x00, bit 1 drives `cfg_prog_n`, bit 2 drives `cfg_write_n`, bit 3 drives `cfg_cs_n` and bit 6 drives `cfg_init_n`. These four bits can be written and read back. Bits 0, 4, 5 and 8–31 read as 0, and writing them has no effect. A pin changes only because of a host write.
- R4: Bit 7 of the control word is read-only. It shows `cfg_done` after a two-flop synchronizer. A read issued in the same cycle that `cfg_done` rises still returns the old value, and a read issued three or more cycles later returns the new value.
- R5: Offset 0x04 reads 0xD1550101: device code 0xD155 in bits 31:16, version 1 in bits 15:8 and revision 1 in bits 7:0. Writes to offset 0x04 leave it unchanged.
- R6: A write to offset 0xF0 produces a one-cycle `cfg_data_stb` with the written word on `cfg_data`, but only when control bits 2 and 3 are both 0. Otherwise the write produces no strobe. Reads of offset 0xF0 return 0.
- R7: Offset 0xF8 returns the bitwise complement of the last value written to it.
- R8: Requests to offsets 0x08 through 0xEF (both ends included) raise `app_sel` with `app_addr`, `app_we` and `app_wdata` held steady. The cycle completes on the first `app_ack`, and a read returns `app_rdata`. Offsets 0x07 and 0xF0 are not forwarded.
- R9: A forwarded cycle waits at most 16 clock edges for `app_ack`. An acknowledge seen on the 16th edge still completes normally. If no acknowledge arrives, the cycle ends after the 16th edge, and a read returns 0xFFFFFFFF. In both cases `host_ack` rises 17 cycles after the request.
- R10: Offsets 0x01–0x03, 0x05–0x07, 0xF1–0xF7 and 0xF9–0xFF read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Byte offset of the request |
| host_rd | input | 1 | One-cycle read request |
| host_wr | input | 1 | One-cycle write request (wins over read) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | One-cycle completion pulse |
| cfg_prog_n | output | 1 | FPGA program pin, active low |
| cfg_write_n | output | 1 | FPGA configuration write enable, active low |
| cfg_cs_n | output | 1 | FPGA configuration select, active low |
| cfg_init_n | output | 1 | FPGA init hold-off, active low |
| cfg_done | input | 1 | FPGA configuration complete, asynchronous |
| cfg_data | output | 32 | Configuration word toward the FPGA |
| cfg_data_stb | output | 1 | One-cycle strobe for cfg_data |
| app_sel | output | 1 | Forwarded cycle in progress |
| app_we | output | 1 | Forwarded cycle is a write |
| app_addr | output | 8 | Forwarded byte offset |
| app_wdata | output | 32 | Forwarded write data |
| app_rdata | input | 32 | FPGA read data, taken with app_ack |
| app_ack | input | 1 | FPGA acknowledge |

## Verification
The hardest case to reach is the edge of the forwarded-cycle timeout. It needs an acknowledge exactly on the last edge the bridge still waits for, and another run where the acknowledge arrives one edge later or never. The bench models the FPGA as a responder process with a programmable delay, counted in cycles of `app_sel`, and runs it with delays of 3, 16 and "never". It checks the completion latency and the returned word in each case. The synchronizer corner is reached by raising `cfg_done` in the same cycle as a control-word read.

// File: rtl/hcb_pkg.sv
// Package: shared constants, field layout and address decode for the host
// configuration bridge. Assumes byte offsets of HCB_ADDR_W bits.
package hcb_pkg;

    localparam int HCB_ADDR_W = 8;

    // Control-word bit positions seen by the host
    localparam int CTL_PROG_BIT  = 1;
    localparam int CTL_WRITE_BIT = 2;
    localparam int CTL_CS_BIT    = 3;
    localparam int CTL_INIT_BIT  = 6;
    localparam int CTL_DONE_BIT  = 7;

    localparam logic [HCB_ADDR_W-1:0] OFS_CTL     = 8'h00;
    localparam logic [HCB_ADDR_W-1:0] OFS_IDENT   = 8'h04;
    localparam logic [HCB_ADDR_W-1:0] OFS_FWD_LO  = 8'h08;
    localparam logic [HCB_ADDR_W-1:0] OFS_FWD_HI  = 8'hEF;
    localparam logic [HCB_ADDR_W-1:0] OFS_CFGWORD = 8'hF0;
    localparam logic [HCB_ADDR_W-1:0] OFS_MIRROR  = 8'hF8;

    typedef enum logic [2:0] {
        TGT_CTL, TGT_IDENT, TGT_CFGWORD, TGT_MIRROR, TGT_FWD, TGT_NONE
    } hcb_tgt_e;

    // Stored configuration pin levels, all active low
    typedef struct packed {
        logic init_n;
        logic cs_n;
        logic write_n;
        logic prog_n;
    } hcb_pins_t;

    // Exact byte-offset decode of a host request
    function automatic hcb_tgt_e hcb_decode(input logic [HCB_ADDR_W-1:0] a);
        if (a == OFS_CTL)                          return TGT_CTL;
        else if (a == OFS_IDENT)                   return TGT_IDENT;
        else if (a >= OFS_FWD_LO && a <= OFS_FWD_HI) return TGT_FWD;
        else if (a == OFS_CFGWORD)                 return TGT_CFGWORD;
        else if (a == OFS_MIRROR)                  return TGT_MIRROR;
        else                                       return TGT_NONE;
    endfunction

endpackage

// File: rtl/hcb_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2; reset value is 0.
module hcb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hcb_local_regs.sv
// Module: registers held inside the bridge (control word, identification,
// configuration-data port, complementing test register). Every accepted
// request completes one cycle later. Assumes rd and wr are never both high.
module hcb_local_regs
    import hcb_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'hD155_0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  hcb_tgt_e          tgt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_s,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output hcb_pins_t         pins,
    output logic [DATA_W-1:0] cfg_word,
    output logic              cfg_stb
);
    hcb_pins_t         pins_q;
    logic [DATA_W-1:0] mirror_q;
    logic [DATA_W-1:0] ctl_view;
    logic [DATA_W-1:0] rd_mux;
    logic              cfg_ok;

    assign pins   = pins_q;
    assign cfg_ok = !pins_q.cs_n && !pins_q.write_n;

    // Assemble the control word as the host reads it
    always_comb begin
        ctl_view                = '0;
        ctl_view[CTL_PROG_BIT]  = pins_q.prog_n;
        ctl_view[CTL_WRITE_BIT] = pins_q.write_n;
        ctl_view[CTL_CS_BIT]    = pins_q.cs_n;
        ctl_view[CTL_INIT_BIT]  = pins_q.init_n;
        ctl_view[CTL_DONE_BIT]  = done_s;
    end

    // Select read data for the decoded target
    always_comb begin
        case (tgt)
            TGT_CTL:    rd_mux = ctl_view;
            TGT_IDENT:  rd_mux = DATA_W'(ID_VALUE);
            TGT_MIRROR: rd_mux = ~mirror_q;
            default:    rd_mux = '0;
        endcase
    end

    // Update the writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q   <= '{init_n: 1'b1, cs_n: 1'b1, write_n: 1'b1, prog_n: 1'b1};
            mirror_q <= '0;
        end else if (wr) begin
            if (tgt == TGT_CTL) begin
                pins_q.prog_n  <= wdata[CTL_PROG_BIT];
                pins_q.write_n <= wdata[CTL_WRITE_BIT];
                pins_q.cs_n    <= wdata[CTL_CS_BIT];
                pins_q.init_n  <= wdata[CTL_INIT_BIT];
            end
            if (tgt == TGT_MIRROR) mirror_q <= wdata;
        end
    end

    // Issue the configuration-data strobe when qualified
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_stb  <= 1'b0;
            cfg_word <= '0;
        end else begin
            cfg_stb <= wr && (tgt == TGT_CFGWORD) && cfg_ok;
            if (wr && (tgt == TGT_CFGWORD) && cfg_ok) cfg_word <= wdata;
        end
    end

    // Return read data and completion one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= rd || wr;
            rdata <= rd ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/hcb_fwd_port.sv
// Module: forwards one host request into the FPGA window. Holds the request
// until the FPGA acknowledges it or TMO_CYC edges pass; a read that times out
// returns all ones. Assumes start is only asserted while idle.
module hcb_fwd_port
    import hcb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TMO_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  start_we,
    input  logic [HCB_ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0]     start_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rdata,
    output logic                  app_sel,
    output logic                  app_we,
    output logic [HCB_ADDR_W-1:0] app_addr,
    output logic [DATA_W-1:0]     app_wdata,
    input  logic [DATA_W-1:0]     app_rdata,
    input  logic                  app_ack
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

    logic [CNT_W-1:0] wait_q;

    assign app_sel = busy;

    // Run the request/acknowledge/timeout sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            rdata     <= '0;
            wait_q    <= '0;
            app_we    <= 1'b0;
            app_addr  <= '0;
            app_wdata <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy      <= 1'b1;
                    wait_q    <= '0;
                    app_we    <= start_we;
                    app_addr  <= start_addr;
                    app_wdata <= start_wdata;
                end
            end else if (app_ack) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                rdata <= app_we ? '0 : app_rdata;
            end else if (wait_q == CNT_LAST) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                rdata <= app_we ? '0 : '1;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hostcfg_bridge.sv
// Module: top of the host configuration bridge. Decodes each host request,
// steers it to the local registers or the FPGA window, and merges both
// completion paths onto host_ack/host_rdata. Assumes one outstanding request;
// requests arriving while a forwarded cycle is pending are dropped.
module hostcfg_bridge
    import hcb_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          TMO_CYC     = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] DEVICE_CODE = 16'hD155,
    parameter logic [7:0]  VERSION     = 8'h01,
    parameter logic [7:0]  REVISION    = 8'h01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HCB_ADDR_W-1:0] host_addr,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W-1:0]     host_rdata,
    output logic                  host_ack,
    output logic                  cfg_prog_n,
    output logic                  cfg_write_n,
    output logic                  cfg_cs_n,
    output logic                  cfg_init_n,
    input  logic                  cfg_done,
    output logic [DATA_W-1:0]     cfg_data,
    output logic                  cfg_data_stb,
    output logic                  app_sel,
    output logic                  app_we,
    output logic [HCB_ADDR_W-1:0] app_addr,
    output logic [DATA_W-1:0]     app_wdata,
    input  logic [DATA_W-1:0]     app_rdata,
    input  logic                  app_ack
);
    localparam logic [31:0] ID_VALUE = {DEVICE_CODE, VERSION, REVISION};

    hcb_tgt_e          tgt;
    hcb_pins_t         pins;
    logic              accept, loc_rd, loc_wr, fwd_start;
    logic              fwd_busy, fwd_done, loc_ack, done_s;
    logic [DATA_W-1:0] loc_rdata, fwd_rdata;

    // Decode and steer the incoming request
    always_comb begin
        tgt       = hcb_decode(host_addr);
        accept    = !fwd_busy && (host_rd || host_wr);
        loc_wr    = accept && host_wr && (tgt != TGT_FWD);
        loc_rd    = accept && !host_wr && (tgt != TGT_FWD);
        fwd_start = accept && (tgt == TGT_FWD);
    end

    hcb_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cfg_done), .q_sync(done_s)
    );

    hcb_local_regs #(.DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd(loc_rd), .wr(loc_wr), .tgt(tgt),
        .wdata(host_wdata), .done_s(done_s), .rdata(loc_rdata), .ack(loc_ack),
        .pins(pins), .cfg_word(cfg_data), .cfg_stb(cfg_data_stb)
    );

    hcb_fwd_port #(.DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) u_fwd (
        .clk(clk), .rst_n(rst_n), .start(fwd_start), .start_we(host_wr),
        .start_addr(host_addr), .start_wdata(host_wdata), .busy(fwd_busy),
        .done(fwd_done), .rdata(fwd_rdata), .app_sel(app_sel), .app_we(app_we),
        .app_addr(app_addr), .app_wdata(app_wdata), .app_rdata(app_rdata),
        .app_ack(app_ack)
    );

    // Drive pins and merge the two completion paths
    always_comb begin
        cfg_prog_n  = pins.prog_n;
        cfg_write_n = pins.write_n;
        cfg_cs_n    = pins.cs_n;
        cfg_init_n  = pins.init_n;
        host_ack    = loc_ack || fwd_done;
        host_rdata  = fwd_done ? fwd_rdata : loc_rdata;
    end
endmodule

// File: rtl/hostcfg_bridge_chk.sv
// Module: property checker bound to hostcfg_bridge. Watches only top-level
// ports; the forwarded-cycle length is measured with a local counter.
module hostcfg_bridge_chk #(
    parameter int TMO_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       cfg_prog_n,
    input logic       cfg_write_n,
    input logic       cfg_cs_n,
    input logic       cfg_data_stb,
    input logic       app_sel,
    input logic       app_ack,
    input logic [7:0] app_addr
);
    logic [31:0] sel_cnt;

    // Count consecutive cycles of a forwarded access
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_cnt <= '0;
        else if (app_sel) sel_cnt <= sel_cnt + 1;
        else              sel_cnt <= '0;
    end

    AST_STB_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_data_stb |-> (!cfg_cs_n && !cfg_write_n)); // R6
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_data_stb |=> !cfg_data_stb); // R6
    AST_PROG_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_prog_n) |-> $past(host_wr)); // R3
    AST_SEL_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (app_sel && app_ack) |=> !app_sel); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (app_sel && $past(app_sel)) |-> $stable(app_addr)); // R8
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        app_sel |-> (sel_cnt < TMO_CYC)); // R9
endmodule

bind hostcfg_bridge hostcfg_bridge_chk #(.TMO_CYC(TMO_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .cfg_prog_n(cfg_prog_n),
    .cfg_write_n(cfg_write_n), .cfg_cs_n(cfg_cs_n), .cfg_data_stb(cfg_data_stb),
    .app_sel(app_sel), .app_ack(app_ack), .app_addr(app_addr)
);

// File: tb/tb_hostcfg_bridge.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task queues the expected completion of every
// request; a monitor pops and compares on each host_ack. A responder process
// plays the FPGA with a programmable acknowledge delay.
module tb_hostcfg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ack;
    logic        cfg_prog_n, cfg_write_n, cfg_cs_n, cfg_init_n;
    logic        cfg_done = 1'b0;
    logic [31:0] cfg_data;
    logic        cfg_data_stb;
    logic        app_sel, app_we;
    logic [7:0]  app_addr;
    logic [31:0] app_wdata;
    logic [31:0] app_rdata = '0;
    logic        app_ack = 1'b0;

    int nchk = 0, nerr = 0;
    int stb_cnt = 0, fwd_cnt = 0;
    int resp_delay = 3;
    logic [31:0] last_cfg = '0;
    logic [7:0]  last_fwd_addr = '0;
    logic        last_fwd_we = 1'b0;
    logic [31:0] fmem [int];

    bit          q_chk [$];
    logic [31:0] q_exp [$];
    string       q_req [$];

    always #2.5 clk = ~clk;

    hostcfg_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .cfg_prog_n(cfg_prog_n), .cfg_write_n(cfg_write_n),
        .cfg_cs_n(cfg_cs_n), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
        .cfg_data(cfg_data), .cfg_data_stb(cfg_data_stb), .app_sel(app_sel),
        .app_we(app_we), .app_addr(app_addr), .app_wdata(app_wdata),
        .app_rdata(app_rdata), .app_ack(app_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    endtask

    // Driver: queue the expectation, issue a one-cycle request, wait for ack
    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                          input bit chk, input logic [31:0] exp, input string req,
                          output int lat);
        q_chk.push_back(chk); q_exp.push_back(exp); q_req.push_back(req);
        @(negedge clk);
        host_addr = a; host_wr = wr; host_rd = !wr; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        lat = 1;
        while (!host_ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        int l;
        access(1'b1, a, d, 1'b0, '0, "write", l);
    endtask

    task automatic rd32(input logic [7:0] a, input logic [31:0] exp, input string req);
        int l;
        access(1'b0, a, '0, 1'b1, exp, req, l);
    endtask

    // Monitor: compare completions in order and count strobes/forwarded cycles
    initial begin
        logic prev_sel;
        prev_sel = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && host_ack) begin
                if (q_chk.size() == 0) begin
                    nchk++; nerr++;
                    $display("FAIL R2 unexpected ack actual=1 expected=0");
                end else begin
                    bit c; logic [31:0] e; string r;
                    c = q_chk.pop_front(); e = q_exp.pop_front(); r = q_req.pop_front();
                    if (c) check(r, host_rdata, e);
                end
            end
            if (rst_n && cfg_data_stb) begin
                stb_cnt++;
                last_cfg = cfg_data;
            end
            if (app_sel && !prev_sel) begin
                fwd_cnt++;
                last_fwd_addr = app_addr;
                last_fwd_we = app_we;
            end
            prev_sel = app_sel;
        end
    end

    // Responder: acknowledge a forwarded cycle after resp_delay cycles of select
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            app_ack = 1'b0;
            if (app_sel) begin
                cnt++;
                if (cnt == resp_delay) begin
                    app_ack = 1'b1;
                    if (app_we) fmem[int'(app_addr)] = app_wdata;
                    else app_rdata = fmem.exists(int'(app_addr)) ? fmem[int'(app_addr)] : 32'h0;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int lat, s0, f0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pins", {28'h0, cfg_prog_n, cfg_write_n, cfg_cs_n, cfg_init_n}, 32'hF);
        check("R1 idle", {30'h0, app_sel, cfg_data_stb}, 32'h0);
        rd32(8'hF8, 32'hFFFF_FFFF, "R1 test reg");
        access(1'b0, 8'h00, '0, 1'b1, 32'h0000_004E, "R1 ctl word", lat);
        check("R2 local latency", lat, 1);
        @(negedge clk);
        check("R2 ack single", {31'h0, host_ack}, 32'h0);

        // R5: identification
        rd32(8'h04, 32'hD155_0101, "R5 ident");
        wr32(8'h04, 32'h0000_0000);
        rd32(8'h04, 32'hD155_0101, "R5 ident after write");

        // R3: control pins
        wr32(8'h00, 32'hFFFF_FFFF);
        rd32(8'h00, 32'h0000_004E, "R3 unused bits");
        wr32(8'h00, 32'h0000_0000);
        check("R3 pins low", {28'h0, cfg_prog_n, cfg_write_n, cfg_cs_n, cfg_init_n}, 32'h0);
        wr32(8'h00, 32'h0000_0002);
        check("R3 prog only", {28'h0, cfg_prog_n, cfg_write_n, cfg_cs_n, cfg_init_n}, 32'h8);
        rd32(8'h00, 32'h0000_0002, "R3 readback");

        // R6: configuration data port
        s0 = stb_cnt;
        wr32(8'hF0, 32'hCAFE_0001);
        check("R6 strobe count", stb_cnt - s0, 1);
        check("R6 data", last_cfg, 32'hCAFE_0001);
        rd32(8'hF0, 32'h0, "R6 write-only");
        wr32(8'h00, 32'h0000_000A);
        s0 = stb_cnt;
        wr32(8'hF0, 32'h1111_1111);
        wr32(8'h00, 32'h0000_0006);
        wr32(8'hF0, 32'h2222_2222);
        repeat (2) @(negedge clk);
        check("R6 no strobe unqualified", stb_cnt - s0, 0);
        check("R6 data held", cfg_data, 32'hCAFE_0001);
        wr32(8'h00, 32'h0000_0002);

        // R4: done synchronizer
        q_chk.push_back(1'b1); q_exp.push_back(32'h0000_0002); q_req.push_back("R4 same-cycle done");
        @(negedge clk);
        cfg_done = 1'b1; host_addr = 8'h00; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        repeat (3) @(negedge clk);
        rd32(8'h00, 32'h0000_0082, "R4 done seen");

        // R7: complementing test register
        wr32(8'hF8, 32'h1234_5678);
        rd32(8'hF8, 32'hEDCB_A987, "R7 complement");
        wr32(8'hF8, 32'hFFFF_FFFF);
        rd32(8'hF8, 32'h0000_0000, "R7 all ones");

        // R8: forwarded window
        resp_delay = 3;
        access(1'b1, 8'h08, 32'h1111_2222, 1'b0, '0, "R8 write", lat);
        check("R8 write latency", lat, 4);
        check("R8 fwd addr lo", {24'h0, last_fwd_addr}, 32'h08);
        check("R8 fwd we", {31'h0, last_fwd_we}, 32'h1);
        access(1'b0, 8'h08, '0, 1'b1, 32'h1111_2222, "R8 read lo", lat);
        check("R8 read latency", lat, 4);
        wr32(8'hEF, 32'hABCD_EF01);
        check("R8 fwd addr hi", {24'h0, last_fwd_addr}, 32'hEF);
        rd32(8'hEF, 32'hABCD_EF01, "R8 read hi");
        f0 = fwd_cnt;
        rd32(8'h07, 32'h0, "R8 below window");
        check("R8 not forwarded", fwd_cnt - f0, 0);

        // R9: timeout boundary
        resp_delay = 16;
        access(1'b0, 8'h08, '0, 1'b1, 32'h1111_2222, "R9 ack on last edge", lat);
        check("R9 late ack latency", lat, 17);
        resp_delay = 1000;
        access(1'b0, 8'h08, '0, 1'b1, 32'hFFFF_FFFF, "R9 timeout data", lat);
        check("R9 timeout latency", lat, 17);
        resp_delay = 1;
        access(1'b0, 8'h10, '0, 1'b1, 32'h0, "R9 recovery", lat);
        check("R9 recovery latency", lat, 2);

        // R10: unused offsets
        rd32(8'h01, 32'h0, "R10 off 01");
        rd32(8'h05, 32'h0, "R10 off 05");
        rd32(8'hF4, 32'h0, "R10 off F4");
        rd32(8'hFC, 32'h0, "R10 off FC");
        wr32(8'hF4, 32'h5555_5555);
        wr32(8'hFC, 32'h5555_5555);
        wr32(8'h03, 32'hFFFF_FFFF);
        rd32(8'hF8, 32'h0000_0000, "R10 test reg untouched");
        rd32(8'h00, 32'h0000_0082, "R10 ctl untouched");

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", q_chk.size(), 0);
        summary();
        $finish;
    end
endmodule